// File: doc/BRIEF.md
# DSP Accumulator Status Flag Unit

This block holds the 16-bit status word of a fixed-point DSP with 40-bit accumulators. It also regenerates the arithmetic compare flags of that word whenever the execution stage pulses a flag-update strobe.

On each update the six compare bits (mask 0x003F) are first cleared and then set again from the current result. In long mode the result is the 40-bit accumulator value as it reads back after the write, sign-extended. In short mode sign, zero and the top-two-equal flag come from a 16-bit middle-word value, while the range flag is still taken from the whole accumulator. A hold input keeps the range flag unchanged for operations that must not touch it.

Carry and overflow are selectable. They can come straight from the adder, or a small helper can derive them from the two add operands and the accumulator result. Status bits outside the compare mask, such as logic zero and bit 0x0080, change only through a direct full-word write port.

Top module: `dsp_flag_unit`

## Requirements
- R1: A synchronous active-high reset sets the status word to 0x0000.
- R2: In a cycle with neither update strobe nor direct write, the status word keeps its value.
- R3: A direct write loads all 16 bits of the status word and takes priority over an update strobe in the same cycle.
- R4: An update leaves every bit outside the compare mask 0x003F (including 0x0040 and 0x0080) unchanged.
- R5: With the source select at 0, bit 0x0001 takes the carry input and bit 0x0002 takes the overflow input.
- R6: In long mode (mode input 0), bit 0x0004 is set when the 40-bit accumulator is zero, and bit 0x0008 is set when its bit 39 is 1.
- R7: In long mode, bit 0x0020 is set when accumulator bits 31 and 30 are equal.
- R8: In short mode (mode input 1), bits 0x0004, 0x0008 and 0x0020 come from the 16-bit middle word: zero, bit 15, and bits 15 and 14 equal.
- R9: In both modes, when hold is 0, bit 0x0010 is set when the sign-extended accumulator, read as an unsigned 64-bit value, lies in [0x80000000, 0xFFFFFFFF80000000), that is, when it does not fit in signed 32 bits.
- R10: With the range-hold input at 1, an update leaves bit 0x0010 at its previous value.
- R11: With the source select at 1, carry is set when operand A, read unsigned, is greater than the 40-bit accumulator result. Overflow is bit 39 of (A xor R) and (B xor R).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | Flag-update strobe |
| upd_mode | input | 1 | 0 = long (40-bit) result, 1 = short (16-bit) result |
| range_hold | input | 1 | Keep the range flag during this update |
| cv_src | input | 1 | 0 = carry/overflow from inputs, 1 = derived by helper |
| carry_in | input | 1 | Carry from the adder |
| ovf_in | input | 1 | Overflow from the adder |
| op_a | input | 40 | First add operand for the helper |
| op_b | input | 40 | Second add operand for the helper |
| acc_val | input | 40 | Accumulator value after write-back |
| mid_val | input | 16 | Middle-word result for short mode |
| wr_en | input | 1 | Direct full-word write strobe |
| wr_data | input | 16 | Direct write value |
| sr_out | output | 16 | Status word |

## Verification
The assertions assume that reset is asserted from time zero until the first clock edges have passed. They also assume that every input is stable at the rising edge. When the helper is selected, they take the accumulator input to be the result of the add. The stimulus changes inputs only between edges and holds reset for several cycles at the start. In helper sweeps it always drives the accumulator with the wrapped 40-bit sum of the two operands.

// File: rtl/dsp_flag_pkg.sv
package dsp_flag_pkg;
  localparam int SR_W      = 16;
  localparam int ACC_W_DEF = 40;
  localparam int MID_W_DEF = 16;
  localparam int RNG_W_DEF = 32;

  localparam int B_CARRY = 0;
  localparam int B_OVF   = 1;
  localparam int B_ZERO  = 2;
  localparam int B_SIGN  = 3;
  localparam int B_RANGE = 4;
  localparam int B_TOP2  = 5;
  localparam int CMP_W   = 6;

  localparam logic [SR_W-1:0] CMP_MASK = 16'h003F;

  typedef enum logic {
    MODE_LONG  = 1'b0,
    MODE_SHORT = 1'b1
  } flag_mode_e;

  typedef struct packed {
    logic top2;
    logic range;
    logic sign;
    logic zero;
    logic ovf;
    logic carry;
  } cmp_flags_t;
endpackage

// File: rtl/dsp_flag_range.sv
module dsp_flag_range #(
  parameter int ACC_W = 40,
  parameter int RNG_W = 32
) (
  input  logic [ACC_W-1:0] acc,
  output logic             out_of_range
);
  localparam int TOP_N = ACC_W - RNG_W + 1;

  function automatic logic f_outside(input logic [ACC_W-1:0] v);
    logic [TOP_N-1:0] top;
    top = v[ACC_W-1 -: TOP_N];
    return !((top == '0) || (top == '1));
  endfunction

  assign out_of_range = f_outside(acc);
endmodule

// File: rtl/dsp_flag_helper.sv
module dsp_flag_helper #(
  parameter int ACC_W = 40
) (
  input  logic [ACC_W-1:0] a,
  input  logic [ACC_W-1:0] b,
  input  logic [ACC_W-1:0] r,
  output logic             carry,
  output logic             ovf
);
  function automatic logic f_carry(input logic [ACC_W-1:0] x, input logic [ACC_W-1:0] y);
    return x > y;
  endfunction

  function automatic logic f_ovf(input logic [ACC_W-1:0] x, input logic [ACC_W-1:0] y,
                                 input logic [ACC_W-1:0] z);
    logic [ACC_W-1:0] t;
    t = (x ^ z) & (y ^ z);
    return t[ACC_W-1];
  endfunction

  assign carry = f_carry(a, r);
  assign ovf   = f_ovf(a, b, r);
endmodule

// File: rtl/dsp_flag_cond.sv
module dsp_flag_cond
  import dsp_flag_pkg::*;
#(
  parameter int ACC_W = 40,
  parameter int MID_W = 16,
  parameter int RNG_W = 32
) (
  input  flag_mode_e       mode,
  input  logic [ACC_W-1:0] acc,
  input  logic [MID_W-1:0] mid,
  input  logic             carry,
  input  logic             ovf,
  input  logic             range_now,
  input  logic             range_hold,
  input  logic             range_prev,
  output cmp_flags_t       flags
);
  function automatic logic f_pair_eq(input logic hi, input logic lo);
    return hi == lo;
  endfunction

  logic long_zero, long_sign, long_top2;
  logic short_zero, short_sign, short_top2;

  assign long_zero  = (acc == '0);
  assign long_sign  = acc[ACC_W-1];
  assign long_top2  = f_pair_eq(acc[RNG_W-1], acc[RNG_W-2]);
  assign short_zero = (mid == '0);
  assign short_sign = mid[MID_W-1];
  assign short_top2 = f_pair_eq(mid[MID_W-1], mid[MID_W-2]);

  always_comb begin
    flags       = '0;
    flags.carry = carry;
    flags.ovf   = ovf;
    flags.range = range_hold ? range_prev : range_now;
    if (mode == MODE_SHORT) begin
      flags.zero = short_zero;
      flags.sign = short_sign;
      flags.top2 = short_top2;
    end else begin
      flags.zero = long_zero;
      flags.sign = long_sign;
      flags.top2 = long_top2;
    end
  end
endmodule

// File: rtl/dsp_flag_unit.sv
module dsp_flag_unit
  import dsp_flag_pkg::*;
#(
  parameter int ACC_W = ACC_W_DEF,
  parameter int MID_W = MID_W_DEF,
  parameter int RNG_W = RNG_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_en,
  input  logic             upd_mode,
  input  logic             range_hold,
  input  logic             cv_src,
  input  logic             carry_in,
  input  logic             ovf_in,
  input  logic [ACC_W-1:0] op_a,
  input  logic [ACC_W-1:0] op_b,
  input  logic [ACC_W-1:0] acc_val,
  input  logic [MID_W-1:0] mid_val,
  input  logic             wr_en,
  input  logic [SR_W-1:0]  wr_data,
  output logic [SR_W-1:0]  sr_out
);
  logic [SR_W-1:0] sr_q;
  logic            range_evt;
  logic            help_carry, help_ovf;
  logic            sel_carry, sel_ovf;
  logic            upd_fire, wr_fire;
  cmp_flags_t      new_flags;
  logic [SR_W-1:0] upd_word;

  dsp_flag_range #(.ACC_W(ACC_W), .RNG_W(RNG_W)) u_range (
    .acc          (acc_val),
    .out_of_range (range_evt)
  );

  dsp_flag_helper #(.ACC_W(ACC_W)) u_helper (
    .a     (op_a),
    .b     (op_b),
    .r     (acc_val),
    .carry (help_carry),
    .ovf   (help_ovf)
  );

  assign sel_carry = cv_src ? help_carry : carry_in;
  assign sel_ovf   = cv_src ? help_ovf   : ovf_in;

  dsp_flag_cond #(.ACC_W(ACC_W), .MID_W(MID_W), .RNG_W(RNG_W)) u_cond (
    .mode       (flag_mode_e'(upd_mode)),
    .acc        (acc_val),
    .mid        (mid_val),
    .carry      (sel_carry),
    .ovf        (sel_ovf),
    .range_now  (range_evt),
    .range_hold (range_hold),
    .range_prev (sr_q[B_RANGE]),
    .flags      (new_flags)
  );

  assign wr_fire  = wr_en;
  assign upd_fire = upd_en && !wr_en;
  assign upd_word = (sr_q & ~CMP_MASK) | {{(SR_W-CMP_W){1'b0}}, new_flags};

  always_ff @(posedge clk) begin
    if (rst)           sr_q <= '0;
    else if (wr_fire)  sr_q <= wr_data;
    else if (upd_fire) sr_q <= upd_word;
  end

  assign sr_out = sr_q;
endmodule

// File: rtl/dsp_flag_unit_chk.sv
module dsp_flag_unit_chk
  import dsp_flag_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            upd_fire,
  input logic            wr_fire,
  input logic            range_hold,
  input logic            range_evt,
  input logic [SR_W-1:0] wr_data,
  input logic [SR_W-1:0] sr_out
);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!upd_fire && !wr_fire) |=> $stable(sr_out));

  p_write_load_r3: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> (sr_out == $past(wr_data)));

  p_keep_outside_r4: assert property (@(posedge clk) disable iff (rst)
    upd_fire |=> ((sr_out & ~CMP_MASK) == ($past(sr_out) & ~CMP_MASK)));

  p_range_set_r9: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && !range_hold) |=> (sr_out[B_RANGE] == $past(range_evt)));

  p_range_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && range_hold) |=> $stable(sr_out[B_RANGE]));

  p_zero_not_neg_r6: assert property (@(posedge clk) disable iff (rst)
    upd_fire |=> !(sr_out[B_ZERO] && sr_out[B_SIGN]));
endmodule

bind dsp_flag_unit dsp_flag_unit_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .upd_fire   (upd_fire),
  .wr_fire    (wr_fire),
  .range_hold (range_hold),
  .range_evt  (range_evt),
  .wr_data    (wr_data),
  .sr_out     (sr_out)
);

// File: tb/dsp_flag_unit_tb.sv
module dsp_flag_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd_en = 0, upd_mode = 0, range_hold = 0, cv_src = 0;
  logic        carry_in = 0, ovf_in = 0, wr_en = 0;
  logic [39:0] op_a = '0, op_b = '0, acc_val = '0;
  logic [15:0] mid_val = '0, wr_data = '0;
  logic [15:0] sr_out;
  logic [15:0] model;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  dsp_flag_unit u_dut (
    .clk(clk), .rst(rst), .upd_en(upd_en), .upd_mode(upd_mode),
    .range_hold(range_hold), .cv_src(cv_src), .carry_in(carry_in),
    .ovf_in(ovf_in), .op_a(op_a), .op_b(op_b), .acc_val(acc_val),
    .mid_val(mid_val), .wr_en(wr_en), .wr_data(wr_data), .sr_out(sr_out)
  );

  function automatic logic [15:0] predict(input logic [15:0] prev, input logic md,
      input logic [39:0] acc, input logic [15:0] mid, input logic c, input logic v,
      input logic hold);
    logic [63:0] ext;
    logic rng, z, n, t;
    ext = {{24{acc[39]}}, acc};
    rng = (ext >= 64'h0000_0000_8000_0000) && (ext < 64'hFFFF_FFFF_8000_0000);
    if (md) begin
      z = (mid == 16'h0); n = mid[15];
      t = (mid[15:14] == 2'b00) || (mid[15:14] == 2'b11);
    end else begin
      z = (acc == 40'h0); n = acc[39];
      t = (acc[31:30] == 2'b00) || (acc[31:30] == 2'b11);
    end
    return (prev & 16'hFFC0) | {10'h0, t, (hold ? prev[4] : rng), n, z, v, c};
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    n_chk++;
    if (sr_out !== exp) begin
      n_err++;
      $display("FAIL %s: sr_out=%h expected=%h", req, sr_out, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic do_write(input logic [15:0] d);
    wr_en = 1; wr_data = d; tick(); wr_en = 0; model = d;
  endtask

  logic [39:0] acc_set [14];
  logic [15:0] mid_set [8];
  logic [39:0] op_set  [6];

  initial begin
    acc_set = '{40'h00_0000_0000, 40'h00_0000_0001, 40'h00_7FFF_FFFF, 40'h00_8000_0000,
                40'hFF_8000_0000, 40'hFF_7FFF_FFFF, 40'hFF_FFFF_FFFF, 40'h80_0000_0000,
                40'h7F_FFFF_FFFF, 40'h00_4000_0000, 40'h00_C000_0000, 40'h00_3FFF_FFFF,
                40'hFF_BFFF_FFFF, 40'h01_0000_0000};
    mid_set = '{16'h0000, 16'h0001, 16'h4000, 16'h8000, 16'hC000, 16'h3FFF, 16'h7FFF, 16'hFFFF};
    op_set  = '{40'h00_0000_0000, 40'h00_0000_0001, 40'h7F_FFFF_FFFF, 40'h80_0000_0000,
                40'hFF_FFFF_FFFF, 40'h00_8000_0000};
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset", 16'h0000);
    rst = 0;
    model = 16'h0000;

    do_write(16'hA5C0);
    check("R3 write", 16'hA5C0);
    tick();
    check("R2 idle", 16'hA5C0);
    wr_en = 1; wr_data = 16'h1234; upd_en = 1; acc_val = 40'h0;
    tick(); wr_en = 0; upd_en = 0; model = 16'h1234;
    check("R3 write priority", 16'h1234);
    acc_val = 40'hFF_0000_0000; mid_val = 16'h8000; carry_in = 1;
    tick();
    check("R2 idle with inputs", 16'h1234);

    // R4 R5 R6 R7 R8 R9 sweep
    do_write(16'hFFC0);
    for (int i = 0; i < 14; i++)
      for (int j = 0; j < 8; j++)
        for (int m = 0; m < 2; m++)
          for (int cv = 0; cv < 4; cv++) begin
            upd_en = 1; upd_mode = m[0]; range_hold = 0; cv_src = 0;
            acc_val = acc_set[i]; mid_val = mid_set[j];
            carry_in = cv[0]; ovf_in = cv[1];
            tick();
            model = predict(model, m[0], acc_set[i], mid_set[j], cv[0], cv[1], 1'b0);
            check(m[0] ? "R8 R9 R5 R4 short" : "R6 R7 R9 R5 R4 long", model);
          end
    upd_en = 0;

    // R10 hold
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 14; i++) begin
        do_write(s[0] ? 16'h0090 : 16'h0000);
        upd_en = 1; range_hold = 1; upd_mode = i[0]; cv_src = 0;
        carry_in = 0; ovf_in = 0; acc_val = acc_set[i]; mid_val = mid_set[i % 8];
        tick(); upd_en = 0; range_hold = 0;
        model = predict(model, i[0], acc_set[i], mid_set[i % 8], 1'b0, 1'b0, 1'b1);
        check("R10 range hold", model);
      end

    // R11 helper
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++) begin
        logic [40:0] sum;
        logic ov;
        sum = {1'b0, op_set[i]} + {1'b0, op_set[j]};
        ov  = (op_set[i][39] == op_set[j][39]) && (sum[39] != op_set[i][39]);
        upd_en = 1; cv_src = 1; upd_mode = 0; range_hold = 0;
        carry_in = ~sum[40]; ovf_in = ~ov;
        op_a = op_set[i]; op_b = op_set[j]; acc_val = sum[39:0];
        tick();
        model = predict(model, 1'b0, sum[39:0], mid_val, sum[40], ov, 1'b0);
        check("R11 helper carry/overflow", model);
      end
    upd_en = 0; cv_src = 0;

    rst = 1; tick(); rst = 0;
    check("R1 reset mid-run", 16'h0000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule